// File: doc/BRIEF.md
# Clock-Configuration I2C Register Slave

This block is an I2C target that holds six 8-bit configuration registers for a clock generator. Their contents drive a flat parallel bus. Downstream logic decodes that bus into frequency-select, spread-enable and output-enable controls. The block oversamples SCL and SDA with the system clock and recognises START and STOP conditions on the bus. It answers a single 7-bit device address, 0x69, which is 0xD2 as a write byte and 0xD3 as a read byte. It pulls SDA low only to acknowledge a byte or to send a zero data bit.

Access uses a fixed block protocol and has no register pointer. A write first sends two filler bytes and then data for register 0, register 1 and so on. A read first returns a length byte and then the registers in ascending order. The master may stop after any whole byte. Only standard-mode bus speeds are intended.

Top module: `i2c_clkcfg_slave`

## Requirements
- R1: When reset is released, `cfg_o` holds 0xFFFFF03E0124, with register k at bits [8k+7:8k]. The defaults are reg0 0x24, reg1 0x01, reg2 0x3E, reg3 0xF0, reg4 0xFF and reg5 0xFF. SDA is released.
- R2: The address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. Any other address is not acknowledged, and the block ignores the bus until the next START.
- R3: In a write, the first two bytes after the address are acknowledged and their values are discarded. No register changes during those bytes.
- R4: The data bytes that follow arrive MSB first. They are stored into register 0, 1, 2, ... in that order, each is acknowledged, and each write changes exactly one register.
- R5: A STOP after any whole data byte ends the write. Registers already written keep their new values, and the others keep their old ones.
- R6: A data byte becomes a register value only once its 8th bit has been sampled. A byte cut off by STOP before that point is dropped.
- R7: Data bytes beyond register 5 are not acknowledged, and they change no register.
- R8: A read returns the byte 0x06 first, then registers 0 to 5, each MSB first. Bytes requested after register 5 read as 0xFF.
- R9: When the master does not acknowledge a read byte, the block releases SDA and leaves it released until the next START.
- R10: A repeated START returns the block to the address phase. A write that follows it starts again at register 0.
- R11: `sda_oe_o` is only asserted while SCL is low. It is deasserted in the cycle after a START or a STOP is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_o | output | 48 | Register contents, register k at bits [8k+7:8k] |

## Verification
The assertions assume that each SCL level lasts many system clocks, well beyond the synchronizer delay. Under that assumption a register update and an SDA drive change fall inside the SCL high phase and SCL low phase respectively. They also assume the master never issues START or STOP while the block is driving SDA low. The bench master keeps every SCL phase at 10 to 20 system clocks. It changes SDA only while SCL is low, except when it deliberately creates START or STOP. It places those conditions only after the block has released the line.

// File: rtl/i2c_clkcfg_pkg.sv
package i2c_clkcfg_pkg;
  typedef enum logic [2:0] {
    LNK_IDLE,
    LNK_ADDR,
    LNK_CMD,
    LNK_CNT,
    LNK_WDATA,
    LNK_RDATA
  } lnk_state_e;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned BITS_W  = 4;  // counts 0..9 within a byte frame
endpackage

// File: rtl/i2c_clkcfg_sync.sv
module i2c_clkcfg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s      = scl_pipe[STAGES-1];
  assign sda_s      = sda_pipe[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  // SDA moving while SCL stays high marks a bus condition
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_clkcfg_regs.sv
module i2c_clkcfg_regs #(
  parameter int unsigned NUM_REGS = 6,
  parameter int unsigned IDX_W    = 3,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [7:0]            rd_data_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  logic [7:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[g] <= RESET_VAL[g*8 +: 8];
      else if (wr_en_i && wr_idx_i == IDX_W'(g))   regs_q[g] <= wr_data_i;
    end
    assign cfg_o[g*8 +: 8] = regs_q[g];
  end

  always_comb begin
    rd_data_o = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx_i == IDX_W'(i)) rd_data_o = regs_q[i];
    end
  end
endmodule

// File: rtl/i2c_clkcfg_link.sv
module i2c_clkcfg_link
  import i2c_clkcfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 6,
  parameter int unsigned IDX_W    = 3,
  parameter logic [6:0]  DEV_ADDR = 7'h69
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic [7:0]       rd_data_i,
  output logic             sda_oe_o
);
  localparam int unsigned PW = $clog2(NUM_REGS + 2);
  localparam logic [PW-1:0] POS_LAST = PW'(NUM_REGS);
  localparam logic [PW-1:0] POS_SAT  = PW'(NUM_REGS + 1);

  lnk_state_e        state_q, nxt_q;
  logic [BITS_W-1:0] cnt_q;
  logic [7:0]        shift_q, tx_q, byte_in, tx_sel;
  logic [PW-1:0]     pos_q;   // write: next register; read: 0 = length byte
  logic              ack_q, oe_q, is_tx, byte_done;

  assign is_tx     = (state_q == LNK_RDATA);
  assign byte_in   = {shift_q[6:0], sda_i};
  assign byte_done = scl_rise_i && !is_tx && state_q != LNK_IDLE && cnt_q == BITS_W'(7);

  assign wr_en_o   = byte_done && state_q == LNK_WDATA && pos_q < POS_LAST;
  assign wr_idx_o  = IDX_W'(pos_q);
  assign wr_data_o = byte_in;
  assign rd_idx_o  = IDX_W'(pos_q - PW'(1));

  always_comb begin
    if (pos_q == '0)             tx_sel = 8'(NUM_REGS);
    else if (pos_q <= POS_LAST)  tx_sel = rd_data_i;
    else                         tx_sel = 8'hFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LNK_IDLE;
      nxt_q   <= LNK_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      tx_q    <= '0;
      pos_q   <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_i) begin
      state_q <= LNK_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      state_q <= LNK_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (state_q != LNK_IDLE) begin
      if (scl_rise_i) begin
        if (cnt_q < BITS_W'(8)) begin
          cnt_q <= cnt_q + BITS_W'(1);
          if (!is_tx) shift_q <= byte_in;
        end else begin
          cnt_q <= BITS_W'(9);
          if (is_tx) begin
            // acknowledge clock of a read byte: high means master is done
            if (sda_i) nxt_q <= LNK_IDLE;
            else begin
              nxt_q <= LNK_RDATA;
              if (pos_q != POS_SAT) pos_q <= pos_q + PW'(1);
            end
          end
        end
        if (byte_done) begin
          unique case (state_q)
            LNK_ADDR: begin
              if (byte_in[7:1] == DEV_ADDR) begin
                ack_q <= 1'b1;
                nxt_q <= byte_in[0] ? LNK_RDATA : LNK_CMD;
                pos_q <= '0;
              end else begin
                ack_q <= 1'b0;
                nxt_q <= LNK_IDLE;
              end
            end
            LNK_CMD: begin
              ack_q <= 1'b1;
              nxt_q <= LNK_CNT;
            end
            LNK_CNT: begin
              ack_q <= 1'b1;
              nxt_q <= LNK_WDATA;
              pos_q <= '0;
            end
            LNK_WDATA: begin
              ack_q <= (pos_q < POS_LAST);
              nxt_q <= LNK_WDATA;
              if (pos_q < POS_LAST) pos_q <= pos_q + PW'(1);
            end
            default: ;
          endcase
        end
      end else if (scl_fall_i) begin
        if (cnt_q == BITS_W'(8)) begin
          oe_q <= is_tx ? 1'b0 : ack_q;
        end else if (cnt_q == BITS_W'(9)) begin
          cnt_q   <= '0;
          state_q <= nxt_q;
          if (nxt_q == LNK_RDATA) begin
            tx_q <= tx_sel;
            oe_q <= ~tx_sel[7];
          end else begin
            oe_q <= 1'b0;
          end
        end else if (is_tx && cnt_q != '0) begin
          tx_q <= {tx_q[6:0], 1'b1};
          oe_q <= ~tx_q[6];
        end
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_clkcfg_slave.sv
module i2c_clkcfg_slave #(
  parameter int unsigned NUM_REGS    = 6,
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL = 48'hFFFF_F03E_0124
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic             sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  i2c_clkcfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2c_clkcfg_link #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .DEV_ADDR (DEV_ADDR)
  ) u_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .rd_idx_o   (rd_idx),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o)
  );

  i2c_clkcfg_regs #(
    .NUM_REGS  (NUM_REGS),
    .IDX_W     (IDX_W),
    .RESET_VAL (RESET_VAL)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data),
    .cfg_o     (cfg_o)
  );
endmodule

// File: rtl/i2c_clkcfg_chk.sv
module i2c_clkcfg_chk #(
  parameter int unsigned NUM_REGS = 6,
  parameter logic [NUM_REGS*8-1:0] RESET_VAL = '0
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_i,
  input logic                  sda_oe_o,
  input logic [NUM_REGS*8-1:0] cfg_o,
  input logic                  bus_start,
  input logic                  bus_stop,
  input logic                  wr_en
);
  logic [NUM_REGS*8-1:0] cfg_prev;
  logic [NUM_REGS-1:0]   byte_diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_prev <= RESET_VAL;
    else         cfg_prev <= cfg_o;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_diff
    assign byte_diff[g] = (cfg_o[g*8 +: 8] != cfg_prev[g*8 +: 8]);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_defaults_r1: assert (cfg_o == RESET_VAL);
  end

  p_stable_without_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(cfg_o));

  p_single_byte_update_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(byte_diff) <= 1);

  p_commit_scl_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> scl_i);

  p_drive_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);

  p_release_on_stop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_stop |=> !sda_oe_o);

  p_release_on_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_start |=> !sda_oe_o);
endmodule

bind i2c_clkcfg_slave i2c_clkcfg_chk #(
  .NUM_REGS  (NUM_REGS),
  .RESET_VAL (RESET_VAL)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .cfg_o     (cfg_o),
  .bus_start (bus_start),
  .bus_stop  (bus_stop),
  .wr_en     (wr_en)
);

// File: tb/i2c_clkcfg_slave_test.sv
module i2c_clkcfg_slave_test;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_low = 1'b0;
  logic        sda_oe;
  logic [47:0] cfg;
  wire         sda_bus = ~(sda_low | sda_oe);

  i2c_clkcfg_slave uut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .cfg_o    (cfg)
  );

  always #10 clk = ~clk;

  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] obs_q[$];
  int n_chk = 0, n_fail = 0, r11_viol = 0;
  bit done = 0;
  logic [7:0] model [6];

  task automatic expect_val(string r, logic [63:0] v);
    tag_q.push_back(r);
    exp_q.push_back(v);
  endtask

  task automatic observe(logic [63:0] v);
    obs_q.push_back(v);
  endtask

  // monitor: pairs each produced result with the oldest expectation
  initial forever begin
    @(negedge clk);
    while (obs_q.size() > 0 && exp_q.size() > 0) begin
      logic [63:0] e, o;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      o = obs_q.pop_front();
      n_chk++;
      if (o !== e) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", t, o, e);
      end
    end
  end

  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_ni && scl_m && sda_oe !== prev_oe) r11_viol++;
    prev_oe <= sda_oe;
  end

  function automatic logic [47:0] model_cfg();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic wait_q(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_cfg(string r);
    expect_val(r, {16'h0, model_cfg()});
    observe({16'h0, cfg});
  endtask

  task automatic bus_start();
    sda_low = 1'b0; wait_q(Q);
    scl_m = 1'b1;   wait_q(Q);
    sda_low = 1'b1; wait_q(Q);
    scl_m = 1'b0;   wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_low = 1'b1; wait_q(Q);
    scl_m = 1'b1;   wait_q(Q);
    sda_low = 1'b0; wait_q(2*Q);
  endtask

  task automatic send_bit(logic b);
    sda_low = ~b; wait_q(Q);
    scl_m = 1'b1; wait_q(2*Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_low = 1'b0; wait_q(Q);
    scl_m = 1'b1;   wait_q(Q);
    b = sda_bus;    wait_q(Q);
    scl_m = 1'b0;   wait_q(Q);
  endtask

  task automatic wr_byte(logic [7:0] v, logic exp_ack, string r);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    expect_val(r, {63'h0, exp_ack});
    observe({63'h0, ~b});
  endtask

  task automatic rd_byte(logic [7:0] exp, logic mack, string r);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(~mack);
    expect_val(r, {56'h0, exp});
    observe({56'h0, v});
  endtask

  task automatic write_hdr();
    wr_byte(8'hD2, 1'b1, "R2 write address ack");
    wr_byte(8'h5A, 1'b1, "R3 command byte ack");
    wr_byte(8'h33, 1'b1, "R3 count byte ack");
  endtask

  task automatic finish_run();
    wait_q(5);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    model[0] = 8'h24; model[1] = 8'h01; model[2] = 8'h3E;
    model[3] = 8'hF0; model[4] = 8'hFF; model[5] = 8'hFF;
    #1 rst_ni = 1'b0;
    wait_q(5);
    rst_ni = 1'b1;
    wait_q(5);
    check_cfg("R1 reset defaults");
    expect_val("R1 sda released", 64'h0);
    observe({63'h0, sda_oe});

    // full write with dummy bytes
    bus_start();
    write_hdr();
    check_cfg("R3 no change after dummy bytes");
    for (int i = 0; i < 6; i++) begin
      logic [7:0] d;
      d = 8'h10 * 8'(i + 1) + 8'(i);
      wr_byte(d, 1'b1, "R4 data byte ack");
      model[i] = d;
    end
    bus_stop();
    check_cfg("R4 all registers written in order");

    // full read plus one extra
    bus_start();
    wr_byte(8'hD3, 1'b1, "R2 read address ack");
    rd_byte(8'h06, 1'b1, "R8 length byte");
    for (int i = 0; i < 6; i++) rd_byte(model[i], 1'b1, "R8 register readback");
    rd_byte(8'hFF, 1'b0, "R8 past last register");
    bus_stop();

    // short write
    bus_start();
    write_hdr();
    wr_byte(8'hA1, 1'b1, "R5 data ack");
    wr_byte(8'hB2, 1'b1, "R5 data ack");
    model[0] = 8'hA1; model[1] = 8'hB2;
    bus_stop();
    check_cfg("R5 stop after two bytes");

    // byte cut short by STOP
    bus_start();
    write_hdr();
    wr_byte(8'h11, 1'b1, "R6 data ack");
    model[0] = 8'h11;
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    check_cfg("R6 partial byte dropped");

    // overflow
    bus_start();
    write_hdr();
    for (int i = 0; i < 6; i++) begin
      wr_byte(8'hC0 + 8'(i), 1'b1, "R7 data ack");
      model[i] = 8'hC0 + 8'(i);
    end
    wr_byte(8'h99, 1'b0, "R7 seventh byte nack");
    wr_byte(8'h98, 1'b0, "R7 eighth byte nack");
    bus_stop();
    check_cfg("R7 overflow ignored");

    // foreign address
    bus_start();
    wr_byte(8'hA0, 1'b0, "R2 foreign address nack");
    wr_byte(8'h00, 1'b0, "R2 ignored after nack");
    wr_byte(8'h00, 1'b0, "R2 ignored after nack");
    bus_stop();
    check_cfg("R2 foreign transfer no change");

    // master NACK ends read
    bus_start();
    wr_byte(8'hD3, 1'b1, "R9 read address ack");
    rd_byte(8'h06, 1'b1, "R9 length byte");
    rd_byte(model[0], 1'b0, "R9 first register then nack");
    rd_byte(8'hFF, 1'b0, "R9 line released after nack");
    expect_val("R9 sda_oe low after nack", 64'h0);
    observe({63'h0, sda_oe});
    bus_stop();

    // repeated start: write restarts, then read
    bus_start();
    write_hdr();
    wr_byte(8'hE7, 1'b1, "R10 data ack");
    model[0] = 8'hE7;
    bus_start();
    write_hdr();
    wr_byte(8'h3C, 1'b1, "R10 data ack after restart");
    model[0] = 8'h3C;
    bus_start();
    wr_byte(8'hD3, 1'b1, "R10 read address after restart");
    rd_byte(8'h06, 1'b1, "R10 length byte");
    rd_byte(8'h3C, 1'b0, "R10 register 0 from restarted write");
    bus_stop();
    check_cfg("R10 restart writes register 0");

    wait_q(5);
    expect_val("R11 drive change only with SCL low", 64'h0);
    observe(64'(r11_viol));
    wait_q(5);
    done = 1;
    finish_run();
  end
endmodule